// File: doc/BRIEF.md
# USB Transmit Packet Serializer

This block turns a stream of bytes from a link layer into the serial bit stream of one USB packet. A packet is framed only by the transmit-valid input: when valid rises on an idle block, a SYNC field goes out. Bytes are then taken one at a time through a valid/ready handshake and shifted out least significant bit first. Stuffed zero bits are inserted, and the stream is NRZI-encoded. When valid is low at a byte boundary, the block sends the end-of-packet pattern and returns to idle.

The block emits one bit per clock. It drives three signals for an analog driver model: a differential level (1 = J, 0 = K), an output enable, and an SE0 request. A two-bit operating mode selects one of three behaviours: normal encoding, a raw mode that passes payload bits straight to the line without stuffing or NRZI, or a non-driving mode in which the block stays off the line. A speed select picks the full-speed or high-speed SYNC length. Mode and speed select may change only while the block is idle.

Top module: `usbtx_serializer`

## Requirements
- R1: While reset is asserted, and at idle, line_oe is 0, line_se0 is 0, line_lvl is 1 (J) and tx_ready is 0.
- R2: tx_valid is ignored on the first 5 rising clock edges after reset is released. A packet can start at the 6th edge at the earliest.
- R3: The edge that samples tx_valid high on an idle, driving block starts SYNC, and line_oe is 1 from the next cycle. With fs_sel=1, SYNC is the 8 levels K J K J K J K K. With fs_sel=0, SYNC is HS_SYNC_BITS levels of alternating K and J, starting with K and ending in K K.
- R4: Payload bits leave least significant bit first. In modes 0 and 2, each byte occupies DATA_W consecutive cycles, not counting stuffed bits. In mode 0 a 0 bit toggles the line level and a 1 bit holds it.
- R5: In mode 0, after six consecutive payload 1 bits a 0 bit is inserted. The run count starts at zero after SYNC, carries across byte boundaries, and a stuffed bit due after the last byte is sent before EOP.
- R6: tx_ready is 1 only in a cycle whose closing edge captures tx_data, and exactly once per byte. The first byte is captured on the edge after the last SYNC bit.
- R7: When tx_valid is low at a byte boundary, line_oe stays 1 while line_se0 is 1 for 2 cycles. One cycle of J follows, then line_oe returns to 0.
- R8: Mode 2 sends the same SYNC and EOP as mode 0. The payload bits drive line_lvl directly (1 = J, 0 = K), and no bit is stuffed.
- R9: In mode 1 and in the reserved mode 3, tx_valid is ignored: line_oe and tx_ready stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| op_mode | input | 2 | 0 normal, 1 non-driving, 2 raw, 3 reserved (non-driving) |
| fs_sel | input | 1 | 1 selects the full-speed SYNC, 0 the high-speed SYNC |
| tx_valid | input | 1 | Packet framing and byte valid from the link layer |
| tx_data | input | DATA_W | Byte offered for transmission |
| tx_ready | output | 1 | The byte on tx_data is captured at the next edge |
| line_lvl | output | 1 | Differential level to drive, 1 = J, 0 = K |
| line_oe | output | 1 | Driver enable |
| line_se0 | output | 1 | Request to drive single-ended zero |

## Verification
Every single-byte full-speed packet, 0x00 through 0xFF, is compared cycle by cycle with a line model computed in the bench. This sweep separates correct NRZI from inverted or shifted encodings. It also covers every position at which a run of six ones can end, including the case where a stuffed bit falls just before EOP. Multi-byte packets of all ones show that the run count carries across byte boundaries. A high-speed packet exercises the long SYNC, and raw-mode packets of all ones tell apart a block that bypasses stuffing and NRZI from one that does not. Holding tx_valid high straight out of reset, and in the two non-driving modes, shows the hold-off window and the ignored-request behaviour at the outputs.

// File: rtl/usbtx_pkg.sv
`timescale 1ns/1ps
package usbtx_pkg;
   localparam logic [1:0] MODE_NORMAL = 2'd0;
   localparam logic [1:0] MODE_OFF    = 2'd1;
   localparam logic [1:0] MODE_RAW    = 2'd2;
   localparam logic [1:0] MODE_RSVD   = 2'd3;

   typedef enum logic [2:0] {
      LC_HOLD,
      LC_IDLE,
      LC_BIT,
      LC_SE0,
      LC_J
   } line_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SEND,
      ST_EOP
   } tx_state_e;
endpackage

// File: rtl/usbtx_arm.sv
`timescale 1ns/1ps
module usbtx_arm #(
   parameter int ARM_EDGES = 5
) (
   input  logic clk,
   input  logic rst,
   output logic armed
);
   generate
      if (ARM_EDGES < 0) begin : g_bad
         $error("usbtx_arm: ARM_EDGES must not be negative");
      end
      if (ARM_EDGES == 0) begin : g_none
         assign armed = 1'b1;
      end else begin : g_cnt
         localparam int CW = $clog2(ARM_EDGES + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or posedge rst) begin
            if (rst) cnt_q <= '0;
            else if (cnt_q != CW'(ARM_EDGES)) cnt_q <= cnt_q + 1'b1;
         end
         assign armed = (cnt_q == CW'(ARM_EDGES));
      end
   endgenerate

   AST_ARM_STAYS: assert property (@(posedge clk) disable iff (rst)
      armed |=> armed); // R2
endmodule

// File: rtl/usbtx_line.sv
`timescale 1ns/1ps
module usbtx_line
   import usbtx_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  line_cmd_e cmd,
   input  logic      bit_in,
   input  logic      raw,
   output logic      lvl,
   output logic      oe,
   output logic      se0
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         lvl <= 1'b1;
         oe  <= 1'b0;
         se0 <= 1'b0;
      end else begin
         case (cmd)
            LC_IDLE: begin lvl <= 1'b1; oe <= 1'b0; se0 <= 1'b0; end
            LC_BIT: begin
               oe  <= 1'b1;
               se0 <= 1'b0;
               lvl <= raw ? bit_in : (bit_in ? lvl : ~lvl);
            end
            LC_SE0: begin lvl <= 1'b1; oe <= 1'b1; se0 <= 1'b1; end
            LC_J:   begin lvl <= 1'b1; oe <= 1'b1; se0 <= 1'b0; end
            default: ;
         endcase
      end
   end

   AST_SE0_DRIVEN: assert property (@(posedge clk) disable iff (rst)
      se0 |-> oe); // R7
   AST_SE0_TWO: assert property (@(posedge clk) disable iff (rst)
      $rose(se0) |=> se0); // R7
endmodule

// File: rtl/usbtx_serializer.sv
`timescale 1ns/1ps
module usbtx_serializer
   import usbtx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int STUFF_RUN    = 6,
   parameter int FS_SYNC_BITS = 8,
   parameter int HS_SYNC_BITS = 32,
   parameter int ARM_EDGES    = 5,
   parameter int EOP_SE0_BITS = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        op_mode,
   input  logic              fs_sel,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              line_lvl,
   output logic              line_oe,
   output logic              line_se0
);
   localparam int SYNC_MAX = (FS_SYNC_BITS > HS_SYNC_BITS) ? FS_SYNC_BITS : HS_SYNC_BITS;
   localparam int SYNC_CW  = $clog2(SYNC_MAX + 1);
   localparam int BIT_CW   = $clog2(DATA_W);
   localparam int RUN_CW   = $clog2(STUFF_RUN + 1);
   localparam int EOP_CW   = $clog2(EOP_SE0_BITS + 2);

   generate
      if (DATA_W < 2) begin : g_chk_w
         $error("usbtx_serializer: DATA_W must be at least 2");
      end
      if (STUFF_RUN < 1) begin : g_chk_run
         $error("usbtx_serializer: STUFF_RUN must be at least 1");
      end
      if (FS_SYNC_BITS < 2 || HS_SYNC_BITS < 2) begin : g_chk_sync
         $error("usbtx_serializer: SYNC fields need at least 2 bits");
      end
      if (EOP_SE0_BITS < 1) begin : g_chk_eop
         $error("usbtx_serializer: EOP needs at least one SE0 bit");
      end
   endgenerate

   tx_state_e           st_q, st_n;
   logic [SYNC_CW-1:0]  sync_q, sync_n, sync_len;
   logic [RUN_CW-1:0]   ones_q, ones_n;
   logic [BIT_CW-1:0]   left_q, left_n;
   logic [DATA_W-2:0]   sh_q, sh_n;
   logic [EOP_CW-1:0]   eop_q, eop_n;
   line_cmd_e           cmd;
   logic                cbit, craw, take, armed;
   logic                bypass, drive_ok, stuff_due;

   assign bypass    = (op_mode == MODE_RAW);
   assign drive_ok  = (op_mode == MODE_NORMAL) || (op_mode == MODE_RAW);
   assign stuff_due = !bypass && (ones_q == RUN_CW'(STUFF_RUN));
   assign sync_len  = fs_sel ? SYNC_CW'(FS_SYNC_BITS) : SYNC_CW'(HS_SYNC_BITS);
   assign tx_ready  = take;

   usbtx_arm #(.ARM_EDGES(ARM_EDGES)) u_arm (
      .clk(clk), .rst(rst), .armed(armed)
   );

   always_comb begin
      st_n   = st_q;
      sync_n = sync_q;
      ones_n = ones_q;
      left_n = left_q;
      sh_n   = sh_q;
      eop_n  = eop_q;
      cmd    = LC_HOLD;
      cbit   = 1'b1;
      craw   = 1'b0;
      take   = 1'b0;
      case (st_q)
         ST_IDLE: begin
            cmd = LC_IDLE;
            if (armed && drive_ok && tx_valid) begin
               st_n   = ST_SEND;
               cmd    = LC_BIT;
               cbit   = 1'b0;
               sync_n = sync_len - 1'b1;
               ones_n = '0;
               left_n = '0;
            end
         end
         ST_SEND: begin
            if (sync_q != '0) begin
               cmd    = LC_BIT;
               cbit   = (sync_q == SYNC_CW'(1));
               sync_n = sync_q - 1'b1;
            end else if (stuff_due) begin
               cmd    = LC_BIT;
               cbit   = 1'b0;
               ones_n = '0;
            end else if (left_q != '0) begin
               cmd    = LC_BIT;
               cbit   = sh_q[0];
               craw   = bypass;
               sh_n   = sh_q >> 1;
               left_n = left_q - 1'b1;
               ones_n = (bypass || !cbit) ? '0 : ones_q + 1'b1;
            end else if (tx_valid) begin
               take   = 1'b1;
               cmd    = LC_BIT;
               cbit   = tx_data[0];
               craw   = bypass;
               sh_n   = tx_data[DATA_W-1:1];
               left_n = BIT_CW'(DATA_W - 1);
               ones_n = (bypass || !cbit) ? '0 : ones_q + 1'b1;
            end else begin
               cmd   = LC_SE0;
               st_n  = ST_EOP;
               eop_n = EOP_CW'(1);
            end
         end
         ST_EOP: begin
            if (eop_q < EOP_CW'(EOP_SE0_BITS)) begin
               cmd   = LC_SE0;
               eop_n = eop_q + 1'b1;
            end else if (eop_q == EOP_CW'(EOP_SE0_BITS)) begin
               cmd   = LC_J;
               eop_n = eop_q + 1'b1;
            end else begin
               cmd  = LC_IDLE;
               st_n = ST_IDLE;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         sync_q <= '0;
         ones_q <= '0;
         left_q <= '0;
         sh_q   <= '0;
         eop_q  <= '0;
      end else begin
         st_q   <= st_n;
         sync_q <= sync_n;
         ones_q <= ones_n;
         left_q <= left_n;
         sh_q   <= sh_n;
         eop_q  <= eop_n;
      end
   end

   usbtx_line u_line (
      .clk(clk), .rst(rst), .cmd(cmd), .bit_in(cbit), .raw(craw),
      .lvl(line_lvl), .oe(line_oe), .se0(line_se0)
   );

   AST_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
      !armed |=> !line_oe); // R2
   AST_READY_SENDS: assert property (@(posedge clk) disable iff (rst)
      tx_ready |=> (line_oe && !line_se0)); // R6
   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
      ones_q <= RUN_CW'(STUFF_RUN)); // R5
   AST_QUIET_MODE: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE && !drive_ok) |=> !line_oe); // R9
   AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (rst)
      (st_q != ST_SEND) |-> !tx_ready); // R6
endmodule

// File: tb/usbtx_serializer_test.sv
`timescale 1ns/1ps
module usbtx_serializer_test;
   localparam int HS_SYNC = 32;
   localparam int MAXE    = 600;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] op_mode = 2'd0;
   logic       fs_sel = 1'b1;
   logic       tx_valid = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_ready, line_lvl, line_oe, line_se0;

   int nchk = 0;
   int nfail = 0;

   logic [7:0] pkt [16];
   bit e_oe [MAXE];
   bit e_se0 [MAXE];
   bit e_lvl [MAXE];
   int elen;
   int npk, idx, rdy_cnt;
   bit rdy_seen;

   usbtx_serializer #(.DATA_W(8), .STUFF_RUN(6), .FS_SYNC_BITS(8),
                      .HS_SYNC_BITS(HS_SYNC), .ARM_EDGES(5), .EOP_SE0_BITS(2)) uut (
      .clk(clk), .rst(rst), .op_mode(op_mode), .fs_sel(fs_sel),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .line_lvl(line_lvl), .line_oe(line_oe), .line_se0(line_se0)
   );

   always #10 clk = ~clk;

   initial begin
      #(20 * 200000);
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail);
      $finish;
   end

   task automatic chk(bit ok, string tag, int act, int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic push(bit oe, bit se0, bit lvl);
      e_oe[elen] = oe; e_se0[elen] = se0; e_lvl[elen] = lvl;
      elen++;
   endtask

   // Line model built from R3, R4, R5, R7, R8, R1
   task automatic build(int n, bit fs, bit raw);
      bit lvl;
      int ones, slen;
      elen = 0;
      lvl  = 1'b1;
      slen = fs ? 8 : HS_SYNC;
      for (int i = 0; i < slen; i++) begin
         if (i != slen - 1) lvl = ~lvl;
         push(1, 0, lvl);
      end
      ones = 0;
      for (int b = 0; b < n; b++) begin
         for (int j = 0; j < 8; j++) begin
            bit d;
            d = pkt[b][j];
            if (raw) begin
               lvl = d;
               push(1, 0, lvl);
            end else begin
               if (!d) lvl = ~lvl;
               push(1, 0, lvl);
               ones = d ? ones + 1 : 0;
               if (ones == 6) begin
                  lvl = ~lvl;
                  push(1, 0, lvl);
                  ones = 0;
               end
            end
         end
      end
      push(1, 1, 1);
      push(1, 1, 1);
      push(1, 0, 1);
      push(0, 0, 1);
   endtask

   task automatic hs_step();
      if (rdy_seen) begin idx++; rdy_cnt++; end
      tx_valid = (idx < npk);
      tx_data  = (idx < npk) ? pkt[idx] : 8'h00;
      #1;
      rdy_seen = tx_ready;
   endtask

   task automatic run_packet(int n, bit fs, logic [1:0] mode, int delay, string tag);
      int bad;
      bit pre_ok;
      int a_v, e_v;
      npk = n; fs_sel = fs; op_mode = mode;
      build(n, fs, mode == 2'd2);
      idx = 0; rdy_cnt = 0; rdy_seen = 0;
      tx_valid = 1'b1; tx_data = pkt[0];
      #1;
      rdy_seen = tx_ready;
      if (delay > 1) begin
         pre_ok = 1;
         for (int k = 1; k < delay; k++) begin
            @(negedge clk);
            if (line_oe || tx_ready) pre_ok = 0;
            hs_step();
         end
         chk(pre_ok, "R2 hold-off, oe before 6th edge", pre_ok ? 0 : 1, 0);
      end
      bad = -1; a_v = 0; e_v = 0;
      for (int e = 0; e < elen; e++) begin
         @(negedge clk);
         if (bad < 0 && (line_oe != e_oe[e] || line_se0 != e_se0[e] ||
                         (!e_se0[e] && line_lvl != e_lvl[e]))) begin
            bad = e;
            a_v = {line_oe, line_se0, line_lvl};
            e_v = {e_oe[e], e_se0[e], e_lvl[e]};
         end
         hs_step();
      end
      if (bad >= 0) $display("  mismatch at cycle %0d (value = oe,se0,lvl bits)", bad);
      chk(bad < 0, tag, a_v, e_v);
      chk(rdy_cnt == n, "R6 one ready per byte", rdy_cnt, n);
      @(negedge clk);
   endtask

   task automatic quiet_mode(logic [1:0] mode, string tag);
      bit seen;
      op_mode = mode; fs_sel = 1'b1;
      tx_valid = 1'b1; tx_data = 8'hA5;
      seen = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (line_oe || tx_ready) seen = 1;
      end
      tx_valid = 1'b0;
      @(negedge clk);
      if (line_oe) seen = 1;
      op_mode = 2'd0;
      chk(!seen, tag, seen ? 1 : 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!line_oe && !line_se0 && line_lvl && !tx_ready, "R1 reset outputs",
          {line_oe, line_se0, line_lvl, tx_ready}, 4'b0010);
      // release reset and request a packet at once: R2 then R3 FS SYNC
      rst = 1'b0;
      pkt[0] = 8'hC3;
      run_packet(1, 1'b1, 2'd0, 6, "R2 R3 R4 R7 packet after hold-off");
      chk(!line_oe && line_lvl && !line_se0, "R1 idle after packet",
          {line_oe, line_se0, line_lvl}, 3'b001);

      // R4 R5: every single-byte full-speed packet
      for (int v = 0; v < 256; v++) begin
         pkt[0] = 8'(v);
         run_packet(1, 1'b1, 2'd0, 1, "R4 R5 R7 single byte sweep");
      end

      // R5 run carried across byte boundaries
      pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'hFF;
      run_packet(3, 1'b1, 2'd0, 1, "R5 stuffing across bytes");
      pkt[0] = 8'hF0; pkt[1] = 8'h03; pkt[2] = 8'hFC;
      run_packet(3, 1'b1, 2'd0, 1, "R5 split run and stuff before EOP");

      // R3 high-speed SYNC
      pkt[0] = 8'h3F; pkt[1] = 8'h7E; pkt[2] = 8'h81; pkt[3] = 8'hFF;
      run_packet(4, 1'b0, 2'd0, 1, "R3 R5 high-speed packet");

      // R8 raw mode
      pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h00; pkt[3] = 8'hA5;
      run_packet(4, 1'b1, 2'd2, 1, "R8 raw mode full-speed");
      run_packet(4, 1'b0, 2'd2, 1, "R8 raw mode high-speed");

      // R9 non-driving modes
      quiet_mode(2'd1, "R9 mode 1 stays off the line");
      quiet_mode(2'd3, "R9 reserved mode 3 stays off the line");

      pkt[0] = 8'h5A;
      run_packet(1, 1'b1, 2'd0, 1, "R4 normal after quiet modes");

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule